// File: doc/BRIEF.md
# Direct-Mapped Tag Lookup Unit

This block is the tag side of a small first-level read cache for a single core. It accepts one byte-address read at a time, spends a fixed number of cycles comparing the address against a table of stored block numbers, and either finishes the request as a hit or hands the block number to a next-level port and waits there until that level signals completion. No data is held; only the block identity of each line and a valid flag are tracked.

The table has 64 lines of 64-byte blocks by default. An address is split by dropping the byte offset to form a block number, whose low bits pick the line and whose full value is stored as the tag. When the next level finishes a miss with its fill strobe raised, the chosen line takes the new block number, displacing any previous occupant with no write-back. Two saturating counters record the hits and misses decided by the lookup.

Top module: `dmc_cache_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, `done` and `nl_req_valid` are low and both counters read zero.
- R2: The block number is the address shifted right by 6; the line index is the block number modulo 64; the stored and forwarded tag is the full block number (`nl_req_block` carries it), so the 6 low address bits never change the outcome.
- R3: A hit raises `done` with `done_hit` high in the cycle following the 4th rising edge after the accepting edge, and not earlier.
- R4: A miss raises `nl_req_valid` in that same cycle (never earlier) and holds it, with `nl_req_block` unchanged, until the edge at which `nl_req_ready` is high.
- R5: After the next-level handshake, `done` rises with `done_hit` low in the cycle following the edge at which `nl_done` is sampled high.
- R6: A line is written only when `nl_done` and `nl_fill` are high together; it then holds the missed block number and is valid, whatever it held before. A completion without fill leaves the line as it was.
- R7: `req_ready` is low from the accepting edge until `done` is raised; only one request is in flight.
- R8: `hit_count` rises by one at each hit decision and `miss_count` by one at each miss decision, each stopping at its all-ones value.
- R9: `done` is a single-cycle pulse.
- R10: The address sequence 0x0000, 0x0000, 0x0040, 0x0040, 0x1000, 0x0000 from reset, with every miss filled, yields miss, hit, miss, hit, miss, miss and ends with 2 hits and 4 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the read |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_hit | output | 1 | Finished request was a hit |
| nl_req_valid | output | 1 | Miss forwarded to the next level |
| nl_req_ready | input | 1 | Next level takes the forwarded miss |
| nl_req_block | output | ADDR_W-6 | Block number of the forwarded miss |
| nl_done | input | 1 | Next level finished the miss |
| nl_fill | input | 1 | Install the block into the indexed line |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench goes after conflict eviction (two blocks 64 apart sharing line 0), where a design comparing only the index bits instead of the full block number would report false hits, and after a completion without fill, where a design that always writes the line would turn the repeat access into a hit. It stalls the next-level handshake and stretches the response to catch a request that is dropped, re-sent or finished early, and uses the top address bits and nonzero byte offsets to expose a mis-sliced tag. The counters are built narrow so the run drives both into saturation, which a wrapping counter would fail.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_NLREQ  = 2'd2,
        ST_NLWAIT = 2'd3
    } dmc_state_e;

    typedef struct packed {
        logic fin;
        logic hit;
    } dmc_outcome_t;

    localparam int unsigned DMC_DEF_LINES       = 64;
    localparam int unsigned DMC_DEF_BLOCK_BYTES = 64;
    localparam int unsigned DMC_DEF_LOOKUP      = 4;

endpackage

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int unsigned LINES = 64,
    parameter int unsigned BLK_W = 26,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BLK_W-1:0] look_blk,
    output logic             look_hit,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk
);
    logic [LINES-1:0] line_valid;
    logic [BLK_W-1:0] line_tag [LINES];
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] wr_idx;

    assign look_idx = look_blk[IDX_W-1:0];
    assign wr_idx   = wr_blk[IDX_W-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic [BLK_W-1:0] t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                v_q <= 1'b1;
                t_q <= wr_blk;
            end
        end
        assign line_valid[g] = v_q;
        assign line_tag[g]   = t_q;
    end

    always_comb begin
        look_hit = line_valid[look_idx] && (line_tag[look_idx] == look_blk);
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned BLK_W         = 26,
    parameter int unsigned LOOKUP_CYCLES = 4,
    localparam int unsigned TMR_W        = (LOOKUP_CYCLES < 2) ? 1 : $clog2(LOOKUP_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_blk,
    output logic [BLK_W-1:0] cur_blk,
    input  logic             tag_hit,
    output logic             fill_en,
    output logic             nl_req_valid,
    input  logic             nl_req_ready,
    input  logic             nl_done,
    input  logic             nl_fill,
    output dmc_outcome_t     outcome,
    output logic             hit_inc,
    output logic             miss_inc
);
    dmc_state_e       state_q;
    logic [TMR_W-1:0] tmr_q;
    logic             decide;

    assign decide = (state_q == ST_LOOK) && (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            cur_blk <= '0;
            outcome <= '0;
        end else begin
            outcome <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_blk <= req_blk;
                        tmr_q   <= TMR_W'(LOOKUP_CYCLES - 1);
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (tmr_q == '0) begin
                        if (tag_hit) begin
                            outcome <= '{fin: 1'b1, hit: 1'b1};
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_NLREQ;
                        end
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_NLREQ: begin
                    if (nl_req_ready) begin
                        state_q <= ST_NLWAIT;
                    end
                end
                ST_NLWAIT: begin
                    if (nl_done) begin
                        outcome <= '{fin: 1'b1, hit: 1'b0};
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        nl_req_valid = (state_q == ST_NLREQ);
        hit_inc      = decide && tag_hit;
        miss_inc     = decide && !tag_hit;
        fill_en      = (state_q == ST_NLWAIT) && nl_done && nl_fill;
    end
endmodule

// File: rtl/dmc_cache_lookup.sv
module dmc_cache_lookup
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned LINES         = DMC_DEF_LINES,
    parameter int unsigned BLOCK_BYTES   = DMC_DEF_BLOCK_BYTES,
    parameter int unsigned LOOKUP_CYCLES = DMC_DEF_LOOKUP,
    parameter int unsigned CNT_W         = 32,
    localparam int unsigned OFF_W        = $clog2(BLOCK_BYTES),
    localparam int unsigned BLK_W        = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              done_hit,
    output logic              nl_req_valid,
    input  logic              nl_req_ready,
    output logic [BLK_W-1:0]  nl_req_block,
    input  logic              nl_done,
    input  logic              nl_fill,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic [BLK_W-1:0] req_blk;
    logic [BLK_W-1:0] cur_blk;
    logic             tag_hit;
    logic             fill_en;
    logic             hit_inc;
    logic             miss_inc;
    dmc_outcome_t     outcome;
    logic             unused_offset;

    assign req_blk       = req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    dmc_ctrl #(
        .BLK_W        (BLK_W),
        .LOOKUP_CYCLES(LOOKUP_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_blk     (req_blk),
        .cur_blk     (cur_blk),
        .tag_hit     (tag_hit),
        .fill_en     (fill_en),
        .nl_req_valid(nl_req_valid),
        .nl_req_ready(nl_req_ready),
        .nl_done     (nl_done),
        .nl_fill     (nl_fill),
        .outcome     (outcome),
        .hit_inc     (hit_inc),
        .miss_inc    (miss_inc)
    );

    dmc_tag_store #(
        .LINES(LINES),
        .BLK_W(BLK_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .look_blk(cur_blk),
        .look_hit(tag_hit),
        .wr_en   (fill_en),
        .wr_blk  (cur_blk)
    );

    dmc_sat_counter #(.W(CNT_W)) u_hits (
        .clk  (clk),
        .rst  (rst),
        .inc  (hit_inc),
        .count(hit_count)
    );

    dmc_sat_counter #(.W(CNT_W)) u_misses (
        .clk  (clk),
        .rst  (rst),
        .inc  (miss_inc),
        .count(miss_count)
    );

    assign done         = outcome.fin;
    assign done_hit     = outcome.hit;
    assign nl_req_block = cur_blk;
endmodule

// File: rtl/dmc_cache_lookup_chk.sv
module dmc_cache_lookup_chk #(
    parameter int unsigned LOOKUP_CYCLES = 4,
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned BLK_W         = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic             done_hit,
    input logic             nl_req_valid,
    input logic             nl_req_ready,
    input logic [BLK_W-1:0] nl_req_block,
    input logic             nl_done,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    logic [15:0] since_acc;
    logic        waiting;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_acc <= '0;
            waiting   <= 1'b0;
        end else begin
            if (req_valid && req_ready) since_acc <= '0;
            else if (since_acc != 16'hFFFF) since_acc <= since_acc + 1'b1;
            if (nl_req_valid && nl_req_ready) waiting <= 1'b1;
            else if (nl_done) waiting <= 1'b0;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_hit_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (done && done_hit) |-> (since_acc == 16'(LOOKUP_CYCLES)));

    assert_miss_latency_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(nl_req_valid) |-> (since_acc == 16'(LOOKUP_CYCLES)));

    assert_nl_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_block)));

    assert_miss_finish_R5: assert property (@(posedge clk) disable iff (rst)
        (waiting && nl_done) |=> (done && !done_hit));

    assert_hits_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hit_count >= $past(hit_count)));

    assert_misses_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (miss_count >= $past(miss_count)));

    assert_hit_counted_R8: assert property (@(posedge clk) disable iff (rst)
        (done && done_hit && ($past(hit_count) != {CNT_W{1'b1}}))
            |-> (hit_count == CNT_W'($past(hit_count) + 1'b1)));
endmodule

bind dmc_cache_lookup dmc_cache_lookup_chk #(
    .LOOKUP_CYCLES(LOOKUP_CYCLES),
    .CNT_W        (CNT_W),
    .BLK_W        (BLK_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .done_hit    (done_hit),
    .nl_req_valid(nl_req_valid),
    .nl_req_ready(nl_req_ready),
    .nl_req_block(nl_req_block),
    .nl_done     (nl_done),
    .hit_count   (hit_count),
    .miss_count  (miss_count)
);

// File: tb/tb_dmc_cache_lookup.sv
module tb_dmc_cache_lookup;
    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 3;
    localparam int CNT_MAX = 7;
    localparam int BLK_W   = ADDR_W - 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              done;
    logic              done_hit;
    logic              nl_req_valid;
    logic              nl_req_ready = 1'b0;
    logic [BLK_W-1:0]  nl_req_block;
    logic              nl_done = 1'b0;
    logic              nl_fill = 1'b0;
    logic [CNT_W-1:0]  hit_count;
    logic [CNT_W-1:0]  miss_count;

    always #2 clk = ~clk;

    dmc_cache_lookup #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .done(done), .done_hit(done_hit),
        .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
        .nl_req_block(nl_req_block), .nl_done(nl_done), .nl_fill(nl_fill),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit          mdl_valid [64];
    int unsigned mdl_tag   [64];
    int          mdl_hits = 0;
    int          mdl_miss = 0;

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Entered just after a falling edge; leaves just after a falling edge.
    task automatic access(input logic [31:0] addr, input int ready_wait,
                          input int resp_wait, input bit fill, output bit got_hit);
        int unsigned blk = addr >> 6;
        int          idx = int'(blk % 64);
        bit exp_hit = mdl_valid[idx] && (mdl_tag[idx] == blk);
        check_eq("R7", "req_ready idle", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check_eq("R3", "early done", done, 0);
            check_eq("R4", "early nl_req_valid", nl_req_valid, 0);
            check_eq("R7", "req_ready busy", req_ready, 0);
            @(negedge clk);
        end
        got_hit = 1'b0;
        if (exp_hit) begin
            if (mdl_hits < CNT_MAX) mdl_hits++;
            check_eq("R3", "hit done", done, 1);
            check_eq("R3", "hit flag", done_hit, 1);
            check_eq("R8", "hit_count", hit_count, mdl_hits);
            check_eq("R8", "miss_count", miss_count, mdl_miss);
            got_hit = done && done_hit;
        end else begin
            if (mdl_miss < CNT_MAX) mdl_miss++;
            check_eq("R4", "nl_req_valid", nl_req_valid, 1);
            check_eq("R2", "nl_req_block", nl_req_block, blk);
            check_eq("R4", "no done on miss", done, 0);
            check_eq("R8", "miss_count", miss_count, mdl_miss);
            check_eq("R8", "hit_count", hit_count, mdl_hits);
            for (int i = 0; i < ready_wait; i++) begin
                @(negedge clk);
                check_eq("R4", "nl_req_valid held", nl_req_valid, 1);
                check_eq("R4", "nl_req_block held", nl_req_block, blk);
            end
            nl_req_ready = 1'b1;
            @(negedge clk);
            nl_req_ready = 1'b0;
            check_eq("R4", "nl_req_valid dropped", nl_req_valid, 0);
            for (int i = 0; i < resp_wait; i++) begin
                check_eq("R5", "done before nl_done", done, 0);
                @(negedge clk);
            end
            nl_done = 1'b1;
            nl_fill = fill;
            @(negedge clk);
            nl_done = 1'b0;
            nl_fill = 1'b0;
            check_eq("R5", "miss done", done, 1);
            check_eq("R5", "miss flag", done_hit, 0);
            if (fill) begin
                mdl_valid[idx] = 1'b1;
                mdl_tag[idx]   = blk;
            end
        end
        @(negedge clk);
        check_eq("R9", "done pulse ends", done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit h;
        bit seq_exp [6] = '{0, 1, 0, 1, 0, 0};
        logic [31:0] seq_addr [6] = '{32'h0000, 32'h0000, 32'h0040, 32'h0040, 32'h1000, 32'h0000};
        for (int i = 0; i < 64; i++) begin
            mdl_valid[i] = 1'b0;
            mdl_tag[i]   = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_eq("R1", "req_ready", req_ready, 1);
        check_eq("R1", "done", done, 0);
        check_eq("R1", "nl_req_valid", nl_req_valid, 0);
        check_eq("R1", "hit_count", hit_count, 0);
        check_eq("R1", "miss_count", miss_count, 0);

        // R10 reference sequence, also R6 silent eviction at 0x1000
        for (int i = 0; i < 6; i++) begin
            access(seq_addr[i], 0, 2, 1'b1, h);
            check_eq("R10", "sequence outcome", h, seq_exp[i]);
        end
        check_eq("R10", "hits", hit_count, 2);
        check_eq("R10", "misses", miss_count, 4);

        // R6 completion without fill leaves the line untouched
        access(32'h2000, 1, 1, 1'b0, h);
        access(32'h2000, 0, 0, 1'b0, h);
        check_eq("R6", "unfilled repeat misses", h, 0);
        access(32'h0000, 0, 0, 1'b1, h);
        check_eq("R6", "old line kept", h, 1);

        // R4/R5 stalled handshake and slow response; R2 offset ignored
        access(32'h0080, 3, 5, 1'b1, h);
        access(32'h00BF, 0, 0, 1'b1, h);
        check_eq("R2", "offset hit", h, 1);

        // R2 top address bits form part of the tag
        access(32'hFFFF_FFC0, 0, 0, 1'b1, h);
        access(32'hFFFF_FFC5, 0, 0, 1'b1, h);
        check_eq("R2", "high block hit", h, 1);
        access(32'h0000_0FC0, 0, 0, 1'b1, h);
        access(32'hFFFF_FFC0, 0, 0, 1'b1, h);
        check_eq("R6", "high block evicted", h, 0);

        // R8 saturation through a sweep of lines
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 8; i++)
                access(32'(i * 64), 0, 1, 1'b1, h);
        check_eq("R8", "hit_count saturated", hit_count, CNT_MAX);
        check_eq("R8", "miss_count saturated", miss_count, CNT_MAX);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule